// File: doc/BRIEF.md
# System Tick Timer with Compare Interrupt

This peripheral keeps a 64-bit tick counter that advances by one on every clock and never stops. Software reads it as two 32-bit words over a simple register bus. It also provides a single 32-bit compare channel. When the channel is armed and its value equals the low counter word, a sticky match flag is set. While the channel stays armed, that flag drives a level interrupt.

Software reads the current time by reading the high word, then the low word, then the high word again. It schedules an event by writing the compare register to the low word plus a lead, and then setting the arm bit. When the interrupt arrives, software clears the flag and disarms the channel. Reads are combinational. A write takes effect on the clock edge at which `bus_wr` is sampled high.

Top module: `sys_tick_timer`

## Requirements
- R1: During and right after reset, the counter holds the parameter `INIT_COUNT` (default zero). The compare register is zero, the channel is disarmed, the match flag is clear and `irq` is low.
- R2: The counter grows by exactly one on each clock edge out of reset. Its low word reads at byte offset 0x04 and its high word at 0x08. The word is selected by `bus_addr[3:2]`.
- R3: The high word grows by one on exactly the edge where the low word rolls over from 0xFFFFFFFF to 0, and holds at every other edge.
- R4: Writes to offsets 0x04 and 0x08 leave the counter unchanged.
- R5: The compare register is a 32-bit read/write register at offset 0x0C.
- R6: The control/status word at offset 0x00 shows the match flag in bit 0 and the arm bit in bit 4, and every other bit reads zero. A write there loads the arm bit from bit 4 of the write data.
- R7: At any edge where the channel is armed and the compare register equals the low counter word, the match flag is set. Matching uses only the low word, so a target wraps modulo 2^32. The first time the flag is visible, the low word reads target+1.
- R8: While the channel is disarmed, a compare equality never sets the flag.
- R9: Writing 1 to bit 0 of offset 0x00 clears the flag. Writing 0 there leaves the flag as it was.
- R10: If a clearing write and a match fall on the same edge, the flag stays set.
- R11: `irq` is high exactly while the flag is set and the channel is armed. It stays high until one of the two is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter ticks once per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W (4) | Byte address; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt: flag set and channel armed |

## Verification
The assertions assume that `bus_wr` and `bus_addr` are stable around each rising edge. They also assume that a write strobe lasts exactly one edge. The stimulus meets this by changing every input on the falling edge and holding a write for one edge only. The property that covers clearing the flag assumes the clearing write does not coincide with a match. The bench drives that coincidence only in the one test aimed at set-over-clear priority, and there the priority property carries the check. The carry into the high word is tested on a second instance whose counter starts 4096 ticks below a low-word rollover, because the default start value cannot reach one within the run.

// File: rtl/stt_pkg.sv
// Package: shared constants and register selector for the system tick timer.
// Assumes a 32-bit bus and a counter exactly twice the bus width.
package stt_pkg;
    localparam int BUS_W    = 32;
    localparam int CNT_W    = 64;
    localparam int SEL_LSB  = 2;   // byte offset -> word index
    localparam int SEL_W    = 2;
    localparam int FLAG_BIT = 0;   // match flag in control/status word
    localparam int ARM_BIT  = 4;   // compare arm bit in control/status word

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL   = 2'd0,  // 0x00
        SEL_CNT_LO = 2'd1,  // 0x04
        SEL_CNT_HI = 2'd2,  // 0x08
        SEL_CMP    = 2'd3   // 0x0C
    } reg_sel_e;
endpackage

// File: rtl/stt_counter.sv
// Module: free-running tick counter split into a low and a high half.
// The high half advances only when the low half is all ones, so the
// adder depth is one half-width and the carry lands on the wrap edge.
// Assumes CNT_W is even.
module stt_counter #(
    parameter int          CNT_W      = 64,
    parameter logic [63:0] INIT_COUNT = 64'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    localparam int HALF_W = CNT_W / 2;

    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;

    // Low half: count every cycle, load start value in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lo_q <= INIT_COUNT[HALF_W-1:0];
        else        lo_q <= lo_q + HALF_W'(1);
    end

    // High half: step only on the low-half rollover edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= INIT_COUNT[CNT_W-1:HALF_W];
        else if (&lo_q)  hi_q <= hi_q + HALF_W'(1);
    end

    assign count = {hi_q, lo_q};
endmodule

// File: rtl/stt_compare.sv
// Module: one compare channel with arm bit and sticky match flag.
// Compares against the supplied low counter word; a match while armed
// sets the flag, and a set on the same edge wins over a clear.
// Assumes write strobes are single-cycle and already decoded.
module stt_compare #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_wr,
    input  logic         ctrl_wr,
    input  logic [W-1:0] wdata,
    input  logic         clr_req,
    input  logic         arm_wdata,
    input  logic [W-1:0] cnt_lo,
    output logic [W-1:0] cmp_q,
    output logic         arm_q,
    output logic         flag_q
);
    logic hit;

    // Equality against the low word only; a disarmed channel never hits.
    always_comb hit = arm_q && (cmp_q == cnt_lo);

    // Compare register: load on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= wdata;
    end

    // Arm bit: loaded from every control/status write.
    always_ff @(posedge clk) begin
        if (!rst_n)       arm_q <= 1'b0;
        else if (ctrl_wr) arm_q <= arm_wdata;
    end

    // Sticky flag: set on hit, else clear on write-one, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end
endmodule

// File: rtl/sys_tick_timer.sv
// Module: register-mapped system tick timer with one compare interrupt.
// Decodes the bus, feeds the counter low word to the compare channel,
// muxes reads combinationally and forms the level interrupt.
// Assumes ADDR_W >= 4; address bits below the word index are ignored.
module sys_tick_timer
    import stt_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter logic [63:0] INIT_COUNT = 64'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    reg_sel_e          sel;
    logic [CNT_W-1:0]  cnt_q;
    logic [BUS_W-1:0]  cmp_q;
    logic              arm_q;
    logic              flag_q;
    logic              ctrl_wr;
    logic              cmp_wr;
    logic              unused_addr;

    // Word select from the byte address.
    always_comb sel = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
    assign unused_addr = &{1'b0, bus_addr[SEL_LSB-1:0]};

    // Write decode; counter offsets have no write path.
    always_comb begin
        ctrl_wr = bus_wr && (sel == SEL_CTRL);
        cmp_wr  = bus_wr && (sel == SEL_CMP);
    end

    stt_counter #(
        .CNT_W      (CNT_W),
        .INIT_COUNT (INIT_COUNT)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cnt_q)
    );

    stt_compare #(
        .W (BUS_W)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_wr    (cmp_wr),
        .ctrl_wr   (ctrl_wr),
        .wdata     (bus_wdata),
        .clr_req   (ctrl_wr && bus_wdata[FLAG_BIT]),
        .arm_wdata (bus_wdata[ARM_BIT]),
        .cnt_lo    (cnt_q[BUS_W-1:0]),
        .cmp_q     (cmp_q),
        .arm_q     (arm_q),
        .flag_q    (flag_q)
    );

    // Read mux: status packs flag and arm, reserved bits zero.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                bus_rdata[FLAG_BIT] = flag_q;
                bus_rdata[ARM_BIT]  = arm_q;
            end
            SEL_CNT_LO: bus_rdata = cnt_q[BUS_W-1:0];
            SEL_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BUS_W];
            SEL_CMP:    bus_rdata = cmp_q;
            default:    bus_rdata = '0;
        endcase
    end

    // Level interrupt while flagged and armed.
    assign irq = flag_q && arm_q;
endmodule

// File: rtl/stt_checker.sv
// Checker: temporal properties of the system tick timer, bound to the top.
// Assumes single-edge write strobes with inputs stable around the edge.
module stt_checker
    import stt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [BUS_W-1:0]  cmp,
    input logic              arm,
    input logic              flag
);
    logic [SEL_W-1:0] sel;
    logic             match_now;
    logic             clr_now;
    assign sel       = bus_addr[SEL_LSB +: SEL_W];
    assign match_now = arm && (cmp == count[BUS_W-1:0]);
    assign clr_now   = bus_wr && (sel == SEL_CTRL) && bus_wdata[FLAG_BIT];

    // R2: low word steps by one each cycle out of reset
    p_lo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> count[BUS_W-1:0] == $past(count[BUS_W-1:0]) + 32'd1);

    // R3: high word steps on the rollover edge
    p_hi_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count[BUS_W-1:0] == '1) |=> count[CNT_W-1:BUS_W] == $past(count[CNT_W-1:BUS_W]) + 32'd1);

    // R3: high word holds otherwise
    p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count[BUS_W-1:0] != '1) |=> $stable(count[CNT_W-1:BUS_W]));

    // R5: compare register loads the written value
    p_cmp_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_CMP) |=> cmp == $past(bus_wdata));

    // R6: reserved status bits read zero
    p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CTRL) |-> (bus_rdata & ~32'h0000_0011) == 32'h0);

    // R7 and R10: an armed match sets the flag, even against a clear
    p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_now |=> flag);

    // R8: the flag rises only from an armed match
    p_no_disarmed_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(arm));

    // R9: write-one clears when no match competes
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_now && !match_now) |=> !flag);

    // R9: without a clearing write the flag holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_now) |=> flag);

    // R11: interrupt rises only when flag or arm rises
    p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($rose(flag) || $rose(arm)));
endmodule

bind sys_tick_timer stt_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (cnt_q),
    .cmp       (cmp_q),
    .arm       (arm_q),
    .flag      (flag_q)
);

// File: tb/sim_sys_tick_timer.sv
// Bench: table-driven compare scheduling, then directed reset, register,
// priority and rollover tests. Second instance starts near a rollover.
module sim_sys_tick_timer;
    localparam logic [63:0] INIT1 = 64'h0000_0002_FFFF_F000;
    localparam int unsigned LEADS [6] = '{4, 5, 9, 17, 33, 64};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata0, rdata1;
    logic        irq0, irq1;
    logic [63:0] tb_cyc = 64'h0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    // Independent time model: edges since reset release.
    always @(posedge clk) tb_cyc <= rst_n ? tb_cyc + 64'd1 : 64'd0;

    sys_tick_timer u0 (.clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr),
                       .bus_wdata(wdata), .bus_rdata(rdata0), .irq(irq0));
    sys_tick_timer #(.INIT_COUNT(INIT1)) u1 (.clk(clk), .rst_n(rst_n), .bus_wr(wr),
                       .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1), .irq(irq1));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d0, output logic [31:0] d1);
        addr = a; #1;
        d0 = rdata0; d1 = rdata1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d0, d1, tgt;
        logic [63:0] e1;
        bit found;

        // R1: state held in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(4'h4, d0, d1); chk(d0 == 0, "R1 lo", d0, 0); chk(d1 == INIT1[31:0], "R1 lo init", d1, INIT1[31:0]);
        rd(4'h8, d0, d1); chk(d0 == 0, "R1 hi", d0, 0);
        rd(4'hC, d0, d1); chk(d0 == 0, "R1 cmp", d0, 0);
        rd(4'h0, d0, d1); chk(d0 == 0, "R1 status", d0, 0);
        chk(irq0 == 0, "R1 irq", irq0, 0);
        rst_n = 1'b1;

        // R2: counter follows the edge count
        repeat (7) @(negedge clk);
        rd(4'h4, d0, d1); chk(d0 == tb_cyc[31:0], "R2 lo", d0, tb_cyc[31:0]);
        rd(4'h8, d0, d1); chk(d0 == 0, "R2 hi", d0, 0);
        @(negedge clk);

        // R7/R11: table of compare leads
        for (int i = 0; i < 6; i++) begin
            tgt = tb_cyc[31:0] + LEADS[i];
            wr_reg(4'hC, tgt);
            wr_reg(4'h0, 32'h10);
            found = 1'b0;
            for (int k = 0; k < int'(LEADS[i]) + 4 && !found; k++) begin
                rd(4'h4, d0, d1);
                if (irq0) begin
                    found = 1'b1;
                    chk(d0 == tgt + 32'd1, "R7 first-visible lo", d0, tgt + 32'd1);
                end else @(negedge clk);
            end
            chk(found, "R11 irq asserted", found, 1);
            if (found) @(negedge clk);
            rd(4'h0, d0, d1); chk(d0 == 32'h11, "R6 status after match", d0, 32'h11);
            wr_reg(4'h0, 32'h01);
            rd(4'h0, d0, d1); chk(d0 == 32'h0, "R9 cleared", d0, 0);
            chk(irq0 == 0, "R11 irq after clear", irq0, 0);
            @(negedge clk);
        end

        // R4: counter writes ignored
        wr_reg(4'h4, 32'hDEAD_BEEF);
        wr_reg(4'h8, 32'h1234_5678);
        rd(4'h4, d0, d1); chk(d0 == tb_cyc[31:0], "R4 lo", d0, tb_cyc[31:0]);
        rd(4'h8, d0, d1); chk(d0 == 0, "R4 hi", d0, 0);
        @(negedge clk);

        // R5 and R6: compare readback, reserved bits
        wr_reg(4'hC, 32'hA5A5_0F0F);
        rd(4'hC, d0, d1); chk(d0 == 32'hA5A5_0F0F, "R5 readback", d0, 32'hA5A5_0F0F);
        wr_reg(4'h0, 32'hFFFF_FFFE);
        rd(4'h0, d0, d1); chk(d0 == 32'h10, "R6 reserved", d0, 32'h10);
        wr_reg(4'h0, 32'h0);
        rd(4'h0, d0, d1); chk(d0 == 32'h0, "R6 disarm", d0, 0);
        @(negedge clk);

        // R8: equality while disarmed
        tgt = tb_cyc[31:0] + 32'd6;
        wr_reg(4'hC, tgt);
        repeat (12) @(negedge clk);
        rd(4'h0, d0, d1); chk(d0 == 32'h0, "R8 no flag", d0, 0);
        chk(irq0 == 0, "R8 no irq", irq0, 0);

        // R9/R11: write zero keeps flag; disarm drops irq but not flag
        tgt = tb_cyc[31:0] + 32'd6;
        wr_reg(4'hC, tgt);
        wr_reg(4'h0, 32'h10);
        repeat (8) @(negedge clk);
        wr_reg(4'h0, 32'h10);
        rd(4'h0, d0, d1); chk(d0 == 32'h11, "R9 write-zero keeps", d0, 32'h11);
        chk(irq0 == 1, "R11 irq held", irq0, 1);
        wr_reg(4'h0, 32'h00);
        rd(4'h0, d0, d1); chk(d0 == 32'h01, "R11 disarmed flag", d0, 32'h01);
        chk(irq0 == 0, "R11 irq off when disarmed", irq0, 0);
        wr_reg(4'h0, 32'h01);
        rd(4'h0, d0, d1); chk(d0 == 32'h0, "R9 clear", d0, 0);
        @(negedge clk);

        // R10: clear on the matching edge
        tgt = tb_cyc[31:0] + 32'd8;
        wr_reg(4'hC, tgt);
        wr_reg(4'h0, 32'h10);
        found = 1'b0;
        for (int k = 0; k < 12 && !found; k++) begin
            rd(4'h4, d0, d1);
            if (d0 == tgt) found = 1'b1; else @(negedge clk);
        end
        chk(found, "R10 reached target", found, 1);
        wr_reg(4'h0, 32'h11);
        rd(4'h0, d0, d1); chk(d0 == 32'h11, "R10 set wins", d0, 32'h11);
        wr_reg(4'h0, 32'h01);
        @(negedge clk);

        // R3/R7: rollover on the second instance, target past the wrap
        wr_reg(4'hC, 32'h5);
        wr_reg(4'h0, 32'h10);
        while (tb_cyc < 64'hFF8) @(negedge clk);
        for (int k = 0; k < 24; k++) begin
            e1 = INIT1 + tb_cyc;
            rd(4'h4, d0, d1); chk(d1 == e1[31:0], "R3 lo across wrap", d1, e1[31:0]);
            rd(4'h8, d0, d1); chk(d1 == e1[63:32], "R3 hi across wrap", d1, e1[63:32]);
            if (e1[31:0] == 32'h5) chk(irq1 == 0, "R7 irq before wrapped match", irq1, 0);
            if (e1[31:0] == 32'h6) chk(irq1 == 1, "R7 wrapped match", irq1, 1);
            @(negedge clk);
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule